// File: doc/BRIEF.md
# Tag Compare Match Unit

This block is a small synchronous word store with an equality checker folded into its read path, so that it can hold cache tags. A caller presents an address and a key on the same clock edge. The block reads the stored word at that address, registers the key into a capture register, and raises or lowers a match flag depending on whether the two agree. Plain reads and writes use the same address and data path, so one array serves as both data store and tag store.

The capture register loads only when the capture-enable input is high. A write issued with capture-enable low is a fill: it stores the word already held in the capture register, not the value on the data input. A miss can therefore be repaired by a compare followed directly by a fill to the same address. No tag has to be presented a second time.

A mode input sets the output latency. In flow-through mode, read data and the match flag appear after the first clock edge. In pipelined mode each appears one edge later. Output enables for the data bus and for the match pin are modelled as enable signals next to their values. The match enable acts combinationally.

Top module: `tag_match_unit`

## Requirements
- R1: A selected cycle with write high and capture-enable high stores `din` at `addr`. A later read of that address returns it.
- R2: In flow-through mode (`pipe_mode`=0), a selected read with `oe` high drives the stored word on `dout` with `dout_en` high after the first rising edge.
- R3: In pipelined mode (`pipe_mode`=1), read data appears one edge later than in flow-through mode. After the first edge `dout_en` still reflects the previous cycle.
- R4: `dout_en` is low whenever `oe` is low, and after a write or a deselected cycle.
- R5: The capture register loads `din` only in cycles with `cap_en` high. A write with `cap_en` low (fill) stores the captured word and ignores `din`.
- R6: A compare cycle (selected, write low, `cap_en` high) sets the match flag to 1 when all bits of the stored word equal the captured key. A difference in any single bit, including bit 0 and the top bit, sets it to 0.
- R7: The match flag appears on `match` after the first edge in flow-through mode and after the second edge in pipelined mode.
- R8: A selected cycle that is not a compare leaves the match flag at its last value. This covers a read with `cap_en` low and any write.
- R9: A deselected cycle (`sel`=0) sets the match flag to 1, with the same latency as a compare result.
- R10: `match_en` follows `moe` with no clock involved.
- R11: After synchronous reset, `match` is 1 and `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Chip select, high = selected |
| wr | input | 1 | Write request, high = write |
| cap_en | input | 1 | Capture enable for the key register, high = load |
| addr | input | AW | Word address |
| din | input | DW | Write data / compare key |
| oe | input | 1 | Data output enable, asynchronous, high = drive |
| moe | input | 1 | Match output enable, asynchronous, high = drive |
| pipe_mode | input | 1 | 1 = pipelined latency, 0 = flow-through |
| dout | output | DW | Read data value |
| dout_en | output | 1 | Data bus drive enable |
| match | output | 1 | Match flag value |
| match_en | output | 1 | Match pin drive enable (low = high impedance) |

## Verification
Compares are run with a key that equals the stored word, and with keys that differ only in bit 0 or only in the top bit. This shows that every bit takes part in the equality. The same hit and miss sequence is repeated in both latency modes, and outputs are sampled after the first and after the second edge, which separates the flow-through and pipelined timings.

A miss followed by a fill with junk on `din`, and a read with `cap_en` low before a second fill, show that the key register ignores `din` unless capture is enabled. Reads, writes and deselects placed between compares show the difference between holding the flag and forcing it high.

// File: rtl/tcm_pkg.sv
// Package: shared cycle classification for the tag compare match unit.
// Assumes the caller holds sel/wr/cap_en stable around each rising edge.
package tcm_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_READ  = 3'd1,
        OP_CMP   = 3'd2,
        OP_WRITE = 3'd3,
        OP_FILL  = 3'd4
    } tcm_op_e;

    // Classify one clock cycle from the sampled control inputs.
    function automatic tcm_op_e tcm_decode(input logic sel, input logic wr, input logic cap);
        tcm_op_e op;
        if (!sel)          op = OP_IDLE;
        else if (wr &&  cap) op = OP_WRITE;
        else if (wr && !cap) op = OP_FILL;
        else if (cap)      op = OP_CMP;
        else               op = OP_READ;
        return op;
    endfunction

endpackage

// File: rtl/tcm_capture.sv
// Module: tcm_capture
// Holds the compare key. Loads din on every edge where load_i is high.
// wdata_o is the word that a write in this cycle stores: the incoming din
// when loading, otherwise the key already held (fill behaviour).
// Assumes: reset clears the key to zero.
module tcm_capture #(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] din_i,
    output logic [DW-1:0] key_o,
    output logic [DW-1:0] wdata_o
);

    logic [DW-1:0] key_q;

    // Key register: updates only when capture is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)      key_q <= '0;
        else if (load_i) key_q <= din_i;
    end

    // Word seen by the array and comparator in this cycle.
    always_comb begin
        wdata_o = load_i ? din_i : key_q;
    end

    assign key_o = key_q;

    AST_KEY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(key_o)); // R5

endmodule

// File: rtl/tcm_store.sv
// Module: tcm_store
// Word array with one synchronous write port and an asynchronous read of the
// same address. The array content is not reset.
// Assumes: a read and a write in the same cycle never target one another
// (the top module never reads during a write cycle).
module tcm_store #(
    parameter int DW = 18,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rword_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    // Array write: self-timed, lands on the edge that samples the request.
    always_ff @(posedge clk) begin
        if (we_i) mem_q[addr_i] <= wdata_i;
    end

    // Read port: combinational look-up of the addressed word.
    always_comb begin
        rword_o = mem_q[addr_i];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mem_q[$past(addr_i)] == $past(wdata_i))); // R1

endmodule

// File: rtl/tcm_compare.sv
// Module: tcm_compare
// Bitwise equality of the stored word against the key, and the first-stage
// match register. A compare loads the result; a deselect forces the flag
// high; any other selected cycle holds it.
// Assumes: cmp_i is only high while sel_i is high.
module tcm_compare #(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_i,
    input  logic          cmp_i,
    input  logic [DW-1:0] word_i,
    input  logic [DW-1:0] key_i,
    output logic          flag_o
);

    logic [DW-1:0] diff;
    logic          hit;
    logic          flag_q;

    // Per-bit mismatch detectors.
    for (genvar g = 0; g < DW; g++) begin : g_bit
        assign diff[g] = word_i[g] ^ key_i[g];
    end

    // Reduce the mismatch vector into a single hit indication.
    always_comb begin
        hit = ~|diff;
    end

    // Match register: deselect forces high, compare loads, others hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b1;
        else if (!sel_i) flag_q <= 1'b1;
        else if (cmp_i)  flag_q <= hit;
    end

    assign flag_o = flag_q;

    AST_DESEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> flag_o); // R9

    AST_HOLD_NONCMP: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !cmp_i) |=> $stable(flag_o)); // R8

    AST_CMP_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_i |=> (flag_o == ($past(word_i) == $past(key_i)))); // R6

endmodule

// File: rtl/tcm_outsel.sv
// Module: tcm_outsel
// Output staging. Stage one registers read data, read-valid and takes the
// flag from the comparator; stage two delays all three by one more edge.
// pipe_i picks which stage reaches the pins; oe_i and moe_i gate the drive
// enables without a clock.
// Assumes: pipe_i is held static during normal traffic.
module tcm_outsel #(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_i,
    input  logic [DW-1:0] word_i,
    input  logic          flag_i,
    input  logic          pipe_i,
    input  logic          oe_i,
    input  logic          moe_i,
    output logic [DW-1:0] dout_o,
    output logic          dout_en_o,
    output logic          match_o,
    output logic          match_en_o
);

    logic [DW-1:0] d1_q, d2_q;
    logic          r1_q, r2_q;
    logic          m2_q;

    // Stage one: capture the read word and whether this cycle was a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d1_q <= '0;
            r1_q <= 1'b0;
        end else begin
            r1_q <= rd_i;
            if (rd_i) d1_q <= word_i;
        end
    end

    // Stage two: one further edge of delay for pipelined latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d2_q <= '0;
            r2_q <= 1'b0;
            m2_q <= 1'b1;
        end else begin
            d2_q <= d1_q;
            r2_q <= r1_q;
            m2_q <= flag_i;
        end
    end

    // Pin selection by latency mode and asynchronous enables.
    always_comb begin
        dout_o     = pipe_i ? d2_q : d1_q;
        dout_en_o  = oe_i & (pipe_i ? r2_q : r1_q);
        match_o    = pipe_i ? m2_q : flag_i;
        match_en_o = moe_i;
    end

    AST_PIPE_MATCH_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_i |-> (match_o == $past(flag_i))); // R7

    AST_PIPE_DATA_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_i && dout_en_o) |-> $past(rd_i, 2)); // R3

endmodule

// File: rtl/tag_match_unit.sv
// Module: tag_match_unit (top)
// Word store with an integrated tag comparator. Classifies each cycle,
// drives the array write, the key register, the comparator and the output
// staging.
// Assumes: all control and data inputs are synchronous to clk except oe and
// moe; reset is synchronous and active low.
module tag_match_unit
    import tcm_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr,
    input  logic          cap_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    input  logic          oe,
    input  logic          moe,
    input  logic          pipe_mode,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          match,
    output logic          match_en
);

    tcm_op_e       op;
    logic          we;
    logic          rd;
    logic          cmp;
    logic [DW-1:0] key;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rword;
    logic          flag;

    // Cycle classification and derived strobes.
    always_comb begin
        op  = tcm_decode(sel, wr, cap_en);
        we  = (op == OP_WRITE) || (op == OP_FILL);
        rd  = (op == OP_READ)  || (op == OP_CMP);
        cmp = (op == OP_CMP);
    end

    tcm_capture #(.DW(DW)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (cap_en),
        .din_i   (din),
        .key_o   (key),
        .wdata_o (wdata)
    );

    tcm_store #(.DW(DW), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rword_o (rword)
    );

    tcm_compare #(.DW(DW)) u_compare (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (sel),
        .cmp_i  (cmp),
        .word_i (rword),
        .key_i  (wdata),
        .flag_o (flag)
    );

    tcm_outsel #(.DW(DW)) u_outsel (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_i       (rd),
        .word_i     (rword),
        .flag_i     (flag),
        .pipe_i     (pipe_mode),
        .oe_i       (oe),
        .moe_i      (moe),
        .dout_o     (dout),
        .dout_en_o  (dout_en),
        .match_o    (match),
        .match_en_o (match_en)
    );

    logic unused_key;
    assign unused_key = ^key;

    AST_NO_DRIVE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr || !sel) |=> (!dout_en || pipe_mode)); // R4

    AST_FILL_KEEPS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && !cap_en) |-> (wdata == key)); // R5

endmodule

// File: tb/tag_match_unit_tb.sv
// Directed bench for tag_match_unit: one task per scenario.
module tag_match_unit_tb;

    localparam int DW = 18;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sel, wr, cap_en, oe, moe, pipe_mode;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          dout_en, match, match_en;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    tag_match_unit #(.DW(DW), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .cap_en(cap_en),
        .addr(addr), .din(din), .oe(oe), .moe(moe), .pipe_mode(pipe_mode),
        .dout(dout), .dout_en(dout_en), .match(match), .match_en(match_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Apply one cycle at a falling edge; return at the next falling edge.
    task automatic cyc(input logic s, input logic w, input logic c,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
        sel = s; wr = w; cap_en = c; addr = a; din = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic nop();
        cyc(1'b1, 1'b0, 1'b0, '0, 18'h15A5A);
    endtask

    task automatic t_reset();
        chk("R11 match after reset", match, 1);
        chk("R11 dout_en after reset", dout_en, 0);
    endtask

    task automatic t_moe();
        moe = 1'b0; #1;
        chk("R10 match_en low", match_en, 0);
        moe = 1'b1; #1;
        chk("R10 match_en high", match_en, 1);
    endtask

    task automatic t_write_read_flow();
        pipe_mode = 1'b0; oe = 1'b1;
        cyc(1, 1, 1, 6'd2, 18'h2ABCD);
        cyc(1, 1, 1, 6'd3, 18'h00001);
        cyc(1, 0, 0, 6'd2, 18'h0);
        chk("R1 R2 flow read data", dout, 18'h2ABCD);
        chk("R2 flow read enable", dout_en, 1);
    endtask

    task automatic t_read_pipe();
        pipe_mode = 1'b1; oe = 1'b1;
        cyc(1, 1, 1, 6'd9, 18'h3F00F);
        cyc(1, 0, 0, 6'd9, 18'h0);
        chk("R3 pipe not yet driven", dout_en, 0);
        nop();
        chk("R3 pipe read data", dout, 18'h3F00F);
        chk("R3 pipe read enable", dout_en, 1);
        pipe_mode = 1'b0;
    endtask

    task automatic t_dout_gate();
        oe = 1'b0;
        cyc(1, 0, 0, 6'd2, 18'h0);
        chk("R4 oe low no drive", dout_en, 0);
        oe = 1'b1;
        cyc(1, 1, 1, 6'd4, 18'h00444);
        chk("R4 write no drive", dout_en, 0);
        cyc(0, 0, 0, 6'd4, 18'h0);
        chk("R4 deselect no drive", dout_en, 0);
    endtask

    task automatic t_compare_flow();
        pipe_mode = 1'b0; oe = 1'b0;
        cyc(1, 0, 1, 6'd2, 18'h2ABCD);
        chk("R6 R7 flow hit", match, 1);
        cyc(1, 0, 1, 6'd2, 18'h2ABCC);
        chk("R6 flow miss bit0", match, 0);
        cyc(1, 0, 1, 6'd2, 18'h2ABCD);
        chk("R6 flow hit again", match, 1);
        cyc(1, 0, 1, 6'd2, 18'h0ABCD);
        chk("R6 flow miss top bit", match, 0);
    endtask

    task automatic t_compare_pipe();
        pipe_mode = 1'b1;
        cyc(1, 0, 1, 6'd3, 18'h00001);
        chk("R7 pipe still old", match, 0);
        nop();
        chk("R7 pipe hit visible", match, 1);
        cyc(1, 0, 1, 6'd3, 18'h00003);
        chk("R7 pipe old before miss", match, 1);
        nop();
        chk("R6 R7 pipe miss visible", match, 0);
        pipe_mode = 1'b0;
    endtask

    task automatic t_hold();
        pipe_mode = 1'b0;
        cyc(1, 0, 1, 6'd2, 18'h11111);
        chk("R8 setup miss", match, 0);
        cyc(1, 0, 0, 6'd2, 18'h2ABCD);
        chk("R8 read holds", match, 0);
        cyc(1, 1, 1, 6'd7, 18'h00777);
        chk("R8 write holds", match, 0);
        cyc(1, 1, 0, 6'd8, 18'h0);
        chk("R8 fill holds", match, 0);
    endtask

    task automatic t_deselect();
        cyc(1, 0, 1, 6'd2, 18'h22222);
        chk("R9 setup miss", match, 0);
        cyc(0, 0, 1, 6'd2, 18'h22222);
        chk("R9 deselect forces high", match, 1);
    endtask

    task automatic t_fill();
        pipe_mode = 1'b0;
        cyc(1, 1, 1, 6'd5, 18'h05555);
        cyc(1, 0, 1, 6'd5, 18'h1C0DE);
        chk("R5 compare miss before fill", match, 0);
        cyc(1, 1, 0, 6'd5, 18'h3FFFF);
        cyc(1, 0, 1, 6'd5, 18'h1C0DE);
        chk("R5 hit after fill", match, 1);
        oe = 1'b1;
        cyc(1, 0, 0, 6'd5, 18'h0);
        chk("R5 fill stored key", dout, 18'h1C0DE);
        cyc(1, 0, 0, 6'd1, 18'h2BEEF);
        cyc(1, 1, 0, 6'd6, 18'h01234);
        cyc(1, 0, 0, 6'd6, 18'h0);
        chk("R5 key not loaded without cap_en", dout, 18'h1C0DE);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; sel = 1'b0; wr = 1'b0; cap_en = 1'b0; addr = '0; din = '0;
        oe = 1'b0; moe = 1'b1; pipe_mode = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_moe();
        t_write_read_flow();
        t_read_pipe();
        t_dout_gate();
        t_compare_flow();
        t_compare_pipe();
        t_hold();
        t_deselect();
        t_fill();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule